// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small processor core that completes one instruction in every clock cycle. It runs nine instructions: word load, word store, add, subtract, and, or, signed set-less-than, branch-if-equal and an absolute jump. All of its parts sit in one cycle of combinational logic between the program counter and the state elements. These parts are the program counter, a next-sequential adder, a branch-target adder, a 32-entry register file, the ALU, a two-level control decoder, immediate sign extension and the datapath selectors.

The instruction store and the data store are small internal word arrays. Both are read combinationally and indexed by word. An environment loads the instruction array, and may load the data array, before it releases reset. Apart from clock and reset, the only ports are observation taps. They show the current program counter, the register write port and the data-store write port. A checker can follow the architectural effect of every instruction at these taps.

Top module: `sc_core`

## Requirements
- R1: While synchronous reset is high, no register or data-store write is reported. The first edge with reset high sets the program counter to 0 and clears registers 1 to 31. Data-store contents are kept through reset.
- R2: An instruction that is neither a taken branch nor a jump moves the program counter to PC+4 at the next rising edge.
- R3: Opcode 000000 selects register operations by funct [5:0]. The codes are 100000 add, 100010 subtract, 100100 and, 100101 or, and 101010 signed set-less-than. The result is written to the register named by bits [15:11].
- R4: Opcode 100011 loads a word. The address is the register named by [25:21] plus the sign-extended [15:0]. The word goes to the register named by [20:16].
- R5: Opcode 101011 stores the register named by [20:16] at the same computed address. The store tap shows the byte address and the data. No register write occurs.
- R6: Opcode 000100 compares the registers named by [25:21] and [20:16]. When they are equal, the next PC is PC+4 plus the sign-extended [15:0] shifted left by 2. When they differ, it is PC+4.
- R7: Opcode 000010 sets the next PC to the top four bits of PC+4, then [25:0], then two zero bits.
- R8: Register 0 always reads as zero. A write to it is dropped and does not show on the write tap.
- R9: An unknown opcode, or opcode 000000 with an unlisted funct, writes nothing and advances the PC by 4.
- R10: A write lands at the next rising edge, and reads are combinational. The instruction right after a write therefore sees the new value.
- R11: The data store and the instruction store are indexed with address bits [N+1:2], where N is log2 of the word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 32 | Program counter of the instruction now executing |
| dbg_rf_we | output | 1 | A register write takes effect at the coming edge |
| dbg_rf_waddr | output | 5 | Destination register number |
| dbg_rf_wdata | output | 32 | Value being written to the register |
| dbg_dm_we | output | 1 | A data-store write takes effect at the coming edge |
| dbg_dm_addr | output | 32 | Byte address of the data-store access |
| dbg_dm_wdata | output | 32 | Value being stored |

## Verification
The program loads one positive and one negative word. It then runs back-to-back dependent register operations on them. These tell signed from unsigned compare, and they show whether the newest value is seen without delay. Loads and stores use positive and negative offsets, which exercises the sign extension and the word indexing. Branches are placed both ways: equal and not equal, forward and backward (a self-loop), with a jump between them. The run also holds writes to register 0, an unknown opcode and an unlisted funct; only an update of register 0, a write or a wrong PC would show a fault for these. A second reset in the middle of the run, followed by an instruction that reads registers written earlier, shows whether the register file was cleared.

// File: rtl/sc_pkg.sv
package sc_pkg;

   localparam int WORD_W = 32;
   localparam int REG_N  = 32;
   localparam int REG_AW = $clog2(REG_N);

   typedef enum logic [3:0] {
      ALU_AND = 4'b0000,
      ALU_OR  = 4'b0001,
      ALU_ADD = 4'b0010,
      ALU_SUB = 4'b0110,
      ALU_SLT = 4'b0111
   } alu_fn_e;

   typedef enum logic [1:0] {
      AMODE_ADD   = 2'b00,
      AMODE_SUB   = 2'b01,
      AMODE_FIELD = 2'b10
   } alu_mode_e;

   localparam logic [5:0] OPC_REG   = 6'b000000;
   localparam logic [5:0] OPC_JMP   = 6'b000010;
   localparam logic [5:0] OPC_BEQ   = 6'b000100;
   localparam logic [5:0] OPC_LOAD  = 6'b100011;
   localparam logic [5:0] OPC_STORE = 6'b101011;

   localparam logic [5:0] FN_ADD = 6'b100000;
   localparam logic [5:0] FN_SUB = 6'b100010;
   localparam logic [5:0] FN_AND = 6'b100100;
   localparam logic [5:0] FN_OR  = 6'b100101;
   localparam logic [5:0] FN_SLT = 6'b101010;

   typedef struct packed {
      logic      dst_from_rd;
      logic      opb_imm;
      logic      wb_from_mem;
      logic      rf_wr;
      logic      mem_rd;
      logic      mem_wr;
      logic      is_branch;
      logic      is_jump;
      alu_mode_e amode;
   } ctl_t;

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
   import sc_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctl_t       ctl,
   output alu_fn_e    alu_fn,
   output logic       op_known
);

   ctl_t base;
   logic fn_ok;

   // first level: opcode to control word
   always_comb begin
      base     = '0;
      op_known = 1'b1;
      unique case (opcode)
         OPC_REG: begin
            base.dst_from_rd = 1'b1;
            base.rf_wr       = 1'b1;
            base.amode       = AMODE_FIELD;
         end
         OPC_LOAD: begin
            base.opb_imm     = 1'b1;
            base.wb_from_mem = 1'b1;
            base.rf_wr       = 1'b1;
            base.mem_rd      = 1'b1;
            base.amode       = AMODE_ADD;
         end
         OPC_STORE: begin
            base.opb_imm = 1'b1;
            base.mem_wr  = 1'b1;
            base.amode   = AMODE_ADD;
         end
         OPC_BEQ: begin
            base.is_branch = 1'b1;
            base.amode     = AMODE_SUB;
         end
         OPC_JMP: begin
            base.is_jump = 1'b1;
         end
         default: op_known = 1'b0;  // R9: all enables stay low
      endcase
   end

   // second level: mode plus funct to ALU function
   always_comb begin
      fn_ok  = 1'b1;
      alu_fn = ALU_ADD;
      case (base.amode)
         AMODE_ADD: alu_fn = ALU_ADD;
         AMODE_SUB: alu_fn = ALU_SUB;
         AMODE_FIELD: begin
            case (funct)
               FN_ADD:  alu_fn = ALU_ADD;
               FN_SUB:  alu_fn = ALU_SUB;
               FN_AND:  alu_fn = ALU_AND;
               FN_OR:   alu_fn = ALU_OR;
               FN_SLT:  alu_fn = ALU_SLT;
               default: fn_ok  = 1'b0;
            endcase
         end
         default: alu_fn = ALU_ADD;
      endcase
   end

   always_comb begin
      ctl       = base;
      ctl.rf_wr = base.rf_wr & fn_ok;  // R9: unlisted funct writes nothing
   end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [DW-1:0] opa,
   input  logic [DW-1:0] opb,
   input  alu_fn_e       fn,
   output logic [DW-1:0] res,
   output logic          is_zero
);

   logic [DW-1:0] diff;

   assign diff = opa - opb;

   always_comb begin
      case (fn)
         ALU_AND: res = opa & opb;
         ALU_OR:  res = opa | opb;
         ALU_ADD: res = opa + opb;
         ALU_SUB: res = diff;
         ALU_SLT: res = {{(DW-1){1'b0}}, ($signed(opa) < $signed(opb))};
         default: res = opa + opb;
      endcase
   end

   assign is_zero = (res == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int NREG = 32,
   parameter int DW   = 32,
   localparam int AW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] ra_a,
   input  logic [AW-1:0] ra_b,
   output logic [DW-1:0] rd_a,
   output logic [DW-1:0] rd_b
);

   initial begin
      assert (NREG >= 2 && (1 << AW) == NREG)
         else $error("sc_regfile: NREG must be a power of two of at least 2");
   end

   logic [DW-1:0] cells [1:NREG-1];

   // register 0 has no storage; writes to it are dropped (R8)
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 1; i < NREG; i++) cells[i] <= '0;
      end else if (we && waddr != '0) begin
         cells[waddr] <= wdata;
      end
   end

   assign rd_a = (ra_a == '0) ? '0 : cells[ra_a];
   assign rd_b = (ra_b == '0) ? '0 : cells[ra_b];

endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int IMEM_WORDS = 64,
   parameter int DMEM_WORDS = 64
) (
   input  logic        clk,
   input  logic        rst,
   output logic [31:0] dbg_pc,
   output logic        dbg_rf_we,
   output logic [4:0]  dbg_rf_waddr,
   output logic [31:0] dbg_rf_wdata,
   output logic        dbg_dm_we,
   output logic [31:0] dbg_dm_addr,
   output logic [31:0] dbg_dm_wdata
);

   localparam int IA = $clog2(IMEM_WORDS);
   localparam int DA = $clog2(DMEM_WORDS);

   initial begin
      assert (IMEM_WORDS >= 2 && (1 << IA) == IMEM_WORDS && IA <= 28)
         else $error("sc_core: IMEM_WORDS must be a power of two");
      assert (DMEM_WORDS >= 2 && (1 << DA) == DMEM_WORDS && DA <= 30)
         else $error("sc_core: DMEM_WORDS must be a power of two");
   end

   // instruction store; filled with no-op words (unlisted funct) until loaded
   logic [31:0] imem [IMEM_WORDS];
   initial begin
      for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
   end
   logic [31:0] dmem [DMEM_WORDS];

   logic [31:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
   logic [31:0] instr, imm_ext, opb, alu_y, rf_a, rf_b, wb_data, ld_data;
   logic [4:0]  rs, rt, rd, wa;
   ctl_t        ctl;
   alu_fn_e     alu_fn;
   logic        op_known, alu_zero, take_br, rf_we_eff, dm_we_eff;
   logic        unused_bits;

   // fetch (R11 word index)
   assign instr = imem[pc_q[IA+1:2]];
   assign rs    = instr[25:21];
   assign rt    = instr[20:16];
   assign rd    = instr[15:11];
   assign unused_bits = ^{instr[10:6], ctl.mem_rd};

   sc_ctrl u_ctrl (
      .opcode   (instr[31:26]),
      .funct    (instr[5:0]),
      .ctl      (ctl),
      .alu_fn   (alu_fn),
      .op_known (op_known)
   );

   assign wa = ctl.dst_from_rd ? rd : rt;
   assign rf_we_eff = ctl.rf_wr & ~rst & (wa != 5'd0);
   assign dm_we_eff = ctl.mem_wr & ~rst;

   sc_regfile #(.NREG(REG_N), .DW(WORD_W)) u_rf (
      .clk   (clk),
      .rst   (rst),
      .we    (rf_we_eff),
      .waddr (wa),
      .wdata (wb_data),
      .ra_a  (rs),
      .ra_b  (rt),
      .rd_a  (rf_a),
      .rd_b  (rf_b)
   );

   assign imm_ext = {{16{instr[15]}}, instr[15:0]};
   assign opb     = ctl.opb_imm ? imm_ext : rf_b;

   sc_alu #(.DW(WORD_W)) u_alu (
      .opa     (rf_a),
      .opb     (opb),
      .fn      (alu_fn),
      .res     (alu_y),
      .is_zero (alu_zero)
   );

   // data store: combinational read, write on edge (R10, R11)
   assign ld_data = dmem[alu_y[DA+1:2]];
   always_ff @(posedge clk) begin
      if (dm_we_eff) dmem[alu_y[DA+1:2]] <= rf_b;
   end

   assign wb_data = ctl.wb_from_mem ? ld_data : alu_y;

   // next PC
   assign pc_plus4   = pc_q + 32'd4;
   assign br_target  = pc_plus4 + {imm_ext[29:0], 2'b00};
   assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
   assign take_br    = ctl.is_branch & alu_zero;

   always_comb begin
      if (ctl.is_jump)  pc_next = jmp_target;
      else if (take_br) pc_next = br_target;
      else              pc_next = pc_plus4;
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_next;
   end

   assign dbg_pc       = pc_q;
   assign dbg_rf_we    = rf_we_eff;
   assign dbg_rf_waddr = wa;
   assign dbg_rf_wdata = wb_data;
   assign dbg_dm_we    = dm_we_eff;
   assign dbg_dm_addr  = alu_y;
   assign dbg_dm_wdata = rf_b;

   // assertions
   p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
      (!ctl.is_jump && !take_br) |=> (pc_q == $past(pc_q) + 32'd4));

   p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
      (rs == 5'd0) |-> (rf_a == 32'd0));

   p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      !op_known |-> (!rf_we_eff && !dm_we_eff));

   p_store_no_rf_r5: assert property (@(posedge clk) disable iff (rst)
      dm_we_eff |-> !rf_we_eff);

   p_slt_flag_r3: assert property (@(posedge clk) disable iff (rst)
      (alu_fn == ALU_SLT) |-> (alu_y[31:1] == 31'd0));

   p_jump_align_r7: assert property (@(posedge clk) disable iff (rst)
      ctl.is_jump |=> (pc_q[1:0] == 2'b00));

endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [31:0] dbg_pc, dbg_rf_wdata, dbg_dm_addr, dbg_dm_wdata;
   logic [4:0]  dbg_rf_waddr;
   logic        dbg_rf_we, dbg_dm_we;

   sc_core u_dut (
      .clk          (clk),
      .rst          (rst),
      .dbg_pc       (dbg_pc),
      .dbg_rf_we    (dbg_rf_we),
      .dbg_rf_waddr (dbg_rf_waddr),
      .dbg_rf_wdata (dbg_rf_wdata),
      .dbg_dm_we    (dbg_dm_we),
      .dbg_dm_addr  (dbg_dm_addr),
      .dbg_dm_wdata (dbg_dm_wdata)
   );

   int n_cmp  = 0;
   int n_bad  = 0;
   bit done   = 1'b0;

   logic [31:0] prog [64];
   logic [31:0] m_dm [64];
   logic [31:0] m_rf [32];
   logic [31:0] m_pc;

   function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] fn);
      return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] op, int s, int t, int imm);
      return {op, 5'(s), 5'(t), 16'(imm)};
   endfunction
   function automatic logic [31:0] enc_j(int word_idx);
      return {6'b000010, 26'(word_idx)};
   endfunction

   task automatic model_reset();
      m_pc = 32'd0;
      for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
   endtask

   // R1: reset state seen at the ports
   task automatic check_reset();
      n_cmp++;
      if (dbg_pc !== 32'd0 || dbg_rf_we !== 1'b0 || dbg_dm_we !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 reset: pc=%h rf_we=%b dm_we=%b expected pc=0 rf_we=0 dm_we=0",
                  dbg_pc, dbg_rf_we, dbg_dm_we);
      end
   endtask

   // behavioural reference: execute the instruction at m_pc, compare, advance
   task automatic step_check();
      logic [31:0] ins, a, b, imm, res, npc, addr;
      logic [5:0]  op, fn;
      int          s, t, d;
      bit          e_rw, e_dw, ok;
      logic [4:0]  e_wa;
      logic [31:0] e_wd, e_da, e_dd;
      string       tag;
      ins = prog[(m_pc >> 2) & 63];
      op = ins[31:26]; fn = ins[5:0];
      s = ins[25:21]; t = ins[20:16]; d = ins[15:11];
      a = m_rf[s]; b = m_rf[t];
      imm = {{16{ins[15]}}, ins[15:0]};
      npc = m_pc + 4;
      e_rw = 0; e_dw = 0; e_wa = 0; e_wd = 0; e_da = 0; e_dd = 0;
      tag = "R2";
      case (op)
         6'b000000: begin
            tag = "R3";
            e_rw = 1;
            case (fn)
               6'b100000: res = a + b;
               6'b100010: res = a - b;
               6'b100100: res = a & b;
               6'b100101: res = a | b;
               6'b101010: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
               default: begin e_rw = 0; tag = "R9"; res = 0; end
            endcase
            if (e_rw) begin
               e_wa = 5'(d); e_wd = res;
               if (d == 0) begin e_rw = 0; tag = "R8"; end
            end
         end
         6'b100011: begin
            tag = "R4";
            addr = a + imm;
            e_wa = 5'(t); e_wd = m_dm[(addr >> 2) & 63];  // R11 word index
            e_rw = (t != 0);
         end
         6'b101011: begin
            tag = "R5";
            e_dw = 1; e_da = a + imm; e_dd = b;
         end
         6'b000100: begin
            tag = "R6";
            if (a == b) npc = m_pc + 4 + (imm << 2);
         end
         6'b000010: begin
            tag = "R7";
            npc = {npc[31:28], ins[25:0], 2'b00};
         end
         default: tag = "R9";
      endcase
      ok = (dbg_pc === m_pc) && (dbg_rf_we === e_rw) && (dbg_dm_we === e_dw);
      if (e_rw) ok = ok && (dbg_rf_waddr === e_wa) && (dbg_rf_wdata === e_wd);
      if (e_dw) ok = ok && (dbg_dm_addr === e_da) && (dbg_dm_wdata === e_dd);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at pc=%h: actual pc=%h rfwe=%b wa=%0d wd=%h dmwe=%b da=%h dd=%h expected pc=%h rfwe=%b wa=%0d wd=%h dmwe=%b da=%h dd=%h",
                  tag, m_pc, dbg_pc, dbg_rf_we, dbg_rf_waddr, dbg_rf_wdata,
                  dbg_dm_we, dbg_dm_addr, dbg_dm_wdata,
                  m_pc, e_rw, e_wa, e_wd, e_dw, e_da, e_dd);
      end
      if (e_rw) m_rf[e_wa] = e_wd;
      if (e_dw) m_dm[(e_da >> 2) & 63] = e_dd;
      m_pc = npc;
   endtask

   initial begin
      #1;
      for (int i = 0; i < 64; i++) prog[i] = 32'd0;
      prog[0]  = enc_r(3, 4, 15, 6'b100000);    // reads r3+r4: zero only if cleared (R1)
      prog[1]  = enc_i(6'b100011, 0, 1, 0);     // lw r1 <- 5
      prog[2]  = enc_i(6'b100011, 0, 2, 4);     // lw r2 <- -3
      prog[3]  = enc_r(1, 2, 3, 6'b100000);     // back-to-back use (R10)
      prog[4]  = enc_r(1, 2, 4, 6'b100010);
      prog[5]  = enc_r(1, 2, 5, 6'b100100);
      prog[6]  = enc_r(1, 2, 6, 6'b100101);
      prog[7]  = enc_r(2, 1, 7, 6'b101010);     // signed: -3 < 5
      prog[8]  = enc_r(1, 2, 8, 6'b101010);
      prog[9]  = enc_r(1, 1, 0, 6'b100000);     // write to r0 dropped (R8)
      prog[10] = enc_r(0, 1, 9, 6'b100000);
      prog[11] = enc_i(6'b101011, 3, 4, 8);     // sw byte addr 10 -> word 2
      prog[12] = enc_i(6'b100011, 3, 10, 6);
      prog[13] = enc_i(6'b100011, 4, 11, -4);   // negative offset
      prog[14] = enc_i(6'b000100, 1, 2, 5);     // not taken
      prog[15] = enc_i(6'b000100, 9, 1, 2);     // taken forward to 18
      prog[16] = enc_r(1, 1, 12, 6'b100000);
      prog[17] = enc_r(1, 1, 13, 6'b100000);
      prog[18] = {6'b111111, 26'h123456};       // unknown opcode (R9)
      prog[19] = enc_r(1, 2, 14, 6'b000111);    // unlisted funct (R9)
      prog[20] = enc_i(6'b000100, 0, 0, 1);
      prog[21] = enc_r(1, 1, 13, 6'b100000);
      prog[22] = enc_j(24);
      prog[23] = enc_r(1, 1, 14, 6'b100000);
      prog[24] = enc_i(6'b101011, 0, 11, 12);
      prog[25] = enc_i(6'b000100, 0, 0, -1);    // backward self-loop
      for (int i = 0; i < 64; i++) begin
         u_dut.imem[i] = prog[i];
         m_dm[i] = (i == 0) ? 32'd5 : (i == 1) ? 32'hFFFF_FFFD : 32'h1000_0000 + 32'(i);
         u_dut.dmem[i] = m_dm[i];
      end
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_reset();
      rst = 1'b0;
      #0.5;
      step_check();
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         step_check();
      end
      // reset in the middle of the run (R1)
      rst = 1'b1;
      @(negedge clk);
      check_reset();
      model_reset();
      rst = 1'b0;
      #0.5;
      step_check();
      for (int c = 0; c < 30; c++) begin
         @(negedge clk);
         step_check();
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not end, actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule